// File: doc/BRIEF.md
# Sequential Shift-Add Multiply-Adder

This block computes `a*x + y` over many clock cycles using one adder of k+1 bits. Operands `a` and `x` are k bits wide, and so is the addend `y`. The result is 2k bits wide. The block retires one bit of the multiplier `x` per cycle, starting with the least-significant bit. On each step it conditionally adds the multiplicand into the upper half of a 2k-bit accumulator and then shifts the whole accumulator right by one place.

The accumulator starts with the addend in its upper half, so after k steps it holds the product plus the addend. The lower half starts with the multiplier. As multiplier bits leave from the bottom, finished product bits enter from the top.

A mode input chooses between unsigned and two's-complement arithmetic:
- In unsigned mode, the adder carry becomes the bit shifted into the top of the accumulator.
- In two's-complement mode, both adder inputs are sign-extended by one bit and the shift is arithmetic.
- In two's-complement mode, the top multiplier bit carries negative weight. The last step therefore subtracts the multiplicand instead of adding it.

A one-cycle `start_i` latches all operands and the mode. `busy_o` then stays high for k cycles, and `done_o` marks the result.

Top module: `seq_mul_add`

## Requirements
- R1: While reset is asserted and after its release, `busy_o` and `done_o` are low and `prod_o` is zero until the first operation completes.
- R2: With `mode_i` = 0, the result equals `a_i*x_i + y_i`, with all three operands read as unsigned, taken modulo 2^(2k). It never overflows.
- R3: With `mode_i` = 1, all three operands are two's-complement. The 2k-bit result equals the two's-complement value `a_i*x_i + y_i`. This includes negative multipliers and the most negative operand values.
- R4: If `start_i` is sampled high while the block is idle, `busy_o` is high for exactly the next k cycles. `done_o` is high in the cycle that follows them, and `prod_o` shows the result in that same cycle.
- R5: `done_o` is high for exactly one cycle per accepted operation. It is never high together with `busy_o`.
- R6: A `start_i` sampled while `busy_o` is high has no effect. It does not alter the running result, does not extend the run and produces no extra `done_o`.
- R7: Operands and mode are captured in the cycle `start_i` is accepted. Changing `a_i`, `x_i`, `y_i` or `mode_i` during a run does not change its result.
- R8: `prod_o` changes only in a cycle where `done_o` is high. Otherwise it holds the last result.
- R9: The parameter WIDTH (k) is at least 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; accepted only while idle |
| mode_i | input | 1 | 0 = unsigned, 1 = two's-complement |
| a_i | input | WIDTH | Multiplicand |
| x_i | input | WIDTH | Multiplier |
| y_i | input | WIDTH | Addend |
| busy_o | output | 1 | High during the k step cycles |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| prod_o | output | 2*WIDTH | Result register `a*x + y` |

## Verification
The bench builds the block with WIDTH = 8. At that size the most negative and the largest operand values are cheap to reach directly, and several hundred random operations cover a large share of all sign combinations of multiplicand, multiplier and addend. An 8-cycle run is also long enough to inject a stray start pulse and to change every input in the middle of an operation. The default WIDTH of 16 is elaborated but not swept.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;
  typedef enum logic {
    MODE_UNSIGNED = 1'b0,
    MODE_SIGNED   = 1'b1
  } mul_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;
endpackage

// File: rtl/seq_mul_ctrl.sv
module seq_mul_ctrl
  import seq_mul_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic done_o
);
  localparam int unsigned CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

  mul_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign busy_o = (state_q == ST_RUN);
  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = busy_o;
  assign last_o = busy_o && (cnt_q == LAST_IDX);
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_o;
      if (load_o) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
      end else if (step_o) begin
        if (last_o) begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/seq_mul_addsub.sv
module seq_mul_addsub
  import seq_mul_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] acc_hi_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  mul_mode_e        mode_i,
  input  logic             bit_i,
  input  logic             neg_i,
  output logic [WIDTH:0]   sum_o
);
  logic           sx;
  logic [WIDTH:0] hi_x;
  logic [WIDTH:0] op_x;

  assign sx   = (mode_i == MODE_SIGNED);
  // one guard bit: zero for unsigned, sign copy for signed
  assign hi_x = {sx & acc_hi_i[WIDTH-1], acc_hi_i};
  assign op_x = bit_i ? {sx & mcand_i[WIDTH-1], mcand_i} : '0;

  always_comb begin
    if (neg_i) sum_o = hi_x - op_x;
    else       sum_o = hi_x + op_x;
  end
endmodule

// File: rtl/seq_mul_dpath.sv
module seq_mul_dpath
  import seq_mul_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic               last_i,
  input  mul_mode_e          mode_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   x_i,
  input  logic [WIDTH-1:0]   y_i,
  output logic [2*WIDTH-1:0] acc_nxt_o
);
  localparam int unsigned PW = 2 * WIDTH;

  mul_mode_e        mode_q;
  logic [WIDTH-1:0] mcand_q;
  logic [WIDTH-1:0] hi_q;
  logic [WIDTH-1:0] lo_q;
  logic [WIDTH:0]   sum;
  logic             neg;
  logic [PW-1:0]    acc_nxt;

  // top multiplier bit has negative weight in signed mode
  assign neg = last_i && (mode_q == MODE_SIGNED) && lo_q[0];

  seq_mul_addsub #(.WIDTH(WIDTH)) addsub_i (
    .acc_hi_i (hi_q),
    .mcand_i  (mcand_q),
    .mode_i   (mode_q),
    .bit_i    (lo_q[0]),
    .neg_i    (neg),
    .sum_o    (sum)
  );

  assign acc_nxt   = {sum, lo_q[WIDTH-1:1]};
  assign acc_nxt_o = acc_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_UNSIGNED;
      mcand_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else if (load_i) begin
      mode_q  <= mode_i;
      mcand_q <= a_i;
      hi_q    <= y_i;
      lo_q    <= x_i;
    end else if (step_i) begin
      hi_q <= acc_nxt[PW-1:WIDTH];
      lo_q <= acc_nxt[WIDTH-1:0];
    end
  end
endmodule

// File: rtl/seq_mul_add.sv
module seq_mul_add
  import seq_mul_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               mode_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   x_i,
  input  logic [WIDTH-1:0]   y_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] prod_o
);
  localparam int unsigned PW = 2 * WIDTH;

  logic          load;
  logic          step;
  logic          last;
  logic [PW-1:0] acc_nxt;
  logic [PW-1:0] prod_q;

  seq_mul_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .busy_o  (busy_o),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last),
    .done_o  (done_o)
  );

  seq_mul_dpath #(.WIDTH(WIDTH)) dpath_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .step_i    (step),
    .last_i    (last),
    .mode_i    (mul_mode_e'(mode_i)),
    .a_i       (a_i),
    .x_i       (x_i),
    .y_i       (y_i),
    .acc_nxt_o (acc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   prod_q <= '0;
    else if (last) prod_q <= acc_nxt;
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/seq_mul_add_chk.sv
module seq_mul_add_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [2*WIDTH-1:0] prod_o
);
  localparam int unsigned KW = $clog2(WIDTH + 1) + 1;

  logic [KW-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 run_cnt <= '0;
    else if (start_i && !busy_o) run_cnt <= '0;
    else if (busy_o)             run_cnt <= run_cnt + 1'b1;
  end

  initial assert_width_min_R9: assert (WIDTH >= 2);

  assert_run_length_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_cnt == KW'(WIDTH)));

  assert_busy_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_cnt < KW'(WIDTH)));

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_no_overlap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  assert_start_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && (run_cnt < KW'(WIDTH - 1))) |=> busy_o);

  assert_prod_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(prod_o) |-> done_o);
endmodule

bind seq_mul_add seq_mul_add_chk #(.WIDTH(WIDTH)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .prod_o  (prod_o)
);

// File: tb/seq_mul_add_tb.sv
module seq_mul_add_tb_top;
  localparam int unsigned W  = 8;
  localparam int unsigned PW = 2 * W;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          mode_i = 1'b0;
  logic [W-1:0]  a_i = '0;
  logic [W-1:0]  x_i = '0;
  logic [W-1:0]  y_i = '0;
  logic          busy_o;
  logic          done_o;
  logic [PW-1:0] prod_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #10 clk_i = ~clk_i;

  seq_mul_add #(.WIDTH(W)) dut_i (
    .clk_i, .rst_ni, .start_i, .mode_i, .a_i, .x_i, .y_i,
    .busy_o, .done_o, .prod_o
  );

  function automatic longint to_val(input logic [W-1:0] v, input logic sgn);
    longint r;
    r = longint'(v);
    if (sgn && v[W-1]) r = r - (longint'(1) << W);
    return r;
  endfunction

  function automatic logic [PW-1:0] model(input logic [W-1:0] a, input logic [W-1:0] x,
                                          input logic [W-1:0] y, input logic sgn);
    longint r;
    r = to_val(a, sgn) * to_val(x, sgn) + to_val(y, sgn);
    return r[PW-1:0];
  endfunction

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  // inj: pulse start mid-run (R6); inputs are also scrambled mid-run (R7)
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic sgn, input bit inj);
    logic [PW-1:0] exp;
    logic [PW-1:0] held;
    string req;
    exp = model(a, x, y, sgn);
    req = sgn ? "R3" : "R2";
    @(negedge clk_i);
    a_i = a; x_i = x; y_i = y; mode_i = sgn; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    a_i = W'($urandom); x_i = W'($urandom); y_i = W'($urandom); mode_i = ~sgn;
    for (int i = 0; i < int'(W) - 1; i++) begin
      @(negedge clk_i);
      start_i = (inj && i == 1);
    end
    start_i = 1'b0;
    check("R4 busy through last step", PW'({busy_o, done_o}), PW'(2'b10));
    @(negedge clk_i);
    check("R4 done after k steps", PW'({busy_o, done_o}), PW'(2'b01));
    check(inj ? "R6 stray start result" : (sgn ? "R3 result" : "R2 result"), prod_o, exp);
    held = prod_o;
    @(negedge clk_i);
    check("R5 done single cycle", PW'({busy_o, done_o}), PW'(2'b00));
    check("R8 result held", prod_o, held);
    if (inj) check("R6 no extra run", PW'(busy_o), PW'(0));
    if (req == "") $display("unreachable");
  endtask

  localparam logic [W-1:0] MAXU = '1;
  localparam logic [W-1:0] MINS = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXS = {1'b0, {(W-1){1'b1}}};

  initial begin
    void'($urandom(32'd2024));
    #5;
    check("R1 reset outputs", {prod_o[PW-3:0], busy_o, done_o}, '0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 idle after reset", {prod_o[PW-3:0], busy_o, done_o}, '0);

    run_op(MAXU, MAXU, MAXU, 1'b0, 1'b0);   // R2 upper corner
    run_op('0, MAXU, 8'd77, 1'b0, 1'b0);    // R2 addend only
    run_op(8'd13, 8'd11, 8'd0, 1'b0, 1'b0); // R2 plain product
    run_op(MINS, MINS, MAXS, 1'b1, 1'b0);   // R3 most negative squared
    run_op(8'd5, MINS, MINS, 1'b1, 1'b0);   // R3 negative multiplier
    run_op(MINS, MAXS, 8'hFF, 1'b1, 1'b0);  // R3 mixed signs
    run_op(MAXU, MAXU, MAXU, 1'b1, 1'b0);   // R3 -1*-1 + -1
    run_op(8'hF3, 8'h02, 8'h10, 1'b1, 1'b1); // R6 with stray start
    run_op(8'hA5, 8'hC3, 8'h3C, 1'b0, 1'b1); // R6 unsigned, R7 scrambled inputs

    for (int n = 0; n < 400; n++) begin
      run_op(W'($urandom), W'($urandom), W'($urandom), 1'($urandom), (n % 7) == 0);
    end

    // R8: result holds across idle cycles
    begin
      logic [PW-1:0] keep;
      keep = prod_o;
      repeat (5) @(negedge clk_i);
      check("R8 idle hold", prod_o, keep);
    end

    finish_run();
  end
endmodule